// File: doc/BRIEF.md
# Twin-Predicated Register Move Sequencer

This block turns one register move, where each side may be a single register or a run of registers, into a stream of register-to-register copy requests. Two independent cursors walk the element positions: one for the source and one for the destination. Each side has its own enable mask of up to `VLMAX` bits. Every cycle, each vector side looks ahead to its next enabled position. If both cursors are still inside the active length, the block issues one copy from `src_base + i` to `dst_base + j`. The same walk produces every move variant:
- broadcast of one value (scalar source, vector destination);
- single-element insert (scalar source, destination mask with one bit set);
- single-element pull-out (vector source, scalar destination);
- plain copy;
- compaction (source mask only);
- expansion into enabled slots (destination mask only).

A pulse on `start` while the block is idle captures the operands. Copy requests then leave on `copy_src`/`copy_dst`, qualified by `copy_valid`, at no more than one per cycle. `done` pulses once when the walk is over. The controller has three states:
- `ST_IDLE` waits for `start`.
- `ST_WALK` issues copies. It leaves on *exhaust*, when a cursor finds no enabled position below the active length, or on *single*, after the only copy of a scalar-to-scalar move.
- `ST_FINISH` raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `twin_pred_mover`

## Requirements
- R1: While reset is held and just after it is released, `busy`, `copy_valid` and `done` are 0.
- R2: A `start` sampled at a clock edge while idle loads all operands. The first copy request, if any, is valid in the cycle right after that edge. At most one copy request is valid per cycle.
- R3: When `src_vec` is 1, the source cursor starts at 0 and skips positions whose `src_pred` bit (bit k for position k) is 0. After each copy it moves one past the position just used, so source positions are used in strictly ascending order.
- R4: When `dst_vec` is 1, the destination cursor behaves the same way using `dst_pred`. This lets one move compact or expand elements.
- R5: When a side is scalar, its cursor stays at 0, its mask has no effect, and every copy uses that side's base register.
- R6: When both sides are scalar and the active length is nonzero, exactly one copy is issued, from `src_base` to `dst_base`.
- R7: The walk ends as soon as either cursor finds no enabled position below the active length. No copy is issued for a position at or above the active length. `done` is high for exactly one cycle, in the cycle after the last `ST_WALK` cycle, and `busy` is 0 in the cycle after that.
- R8: With an active length of 0, no copy is issued and `done` still pulses, in the second cycle after `start` is sampled.
- R9: A value on `vl` greater than `VLMAX` is treated as `VLMAX`.
- R10: Register numbers are formed as (base + position) modulo 2^`RW`.
- R11: `start` has no effect while `busy` is 1, whatever the other inputs carry at that time.
- R12: Skipping over masked positions costs no cycles. With n copies, `done` is seen n+2 cycles after the `start` edge, or 2 cycles for a scalar-to-scalar move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a move (sampled while idle) |
| src_vec | input | 1 | Source is a run of registers |
| dst_vec | input | 1 | Destination is a run of registers |
| src_base | input | RW | First source register |
| dst_base | input | RW | First destination register |
| src_pred | input | VLMAX | Source enable mask, bit k for position k |
| dst_pred | input | VLMAX | Destination enable mask, bit k for position k |
| vl | input | $clog2(VLMAX+1) | Active length, saturated at VLMAX |
| busy | output | 1 | Move in progress (ST_WALK or ST_FINISH) |
| copy_valid | output | 1 | A copy request is present this cycle |
| copy_src | output | RW | Register to read for this copy |
| copy_dst | output | RW | Register to write for this copy |
| done | output | 1 | One-cycle end-of-move pulse |

## Verification
The move is tried with these operand shapes:
- all four scalar/vector combinations;
- full masks, sparse masks on the source only, on the destination only, and on both;
- one-hot masks, which give insert and pull-out;
- an all-zero destination mask.

Full masks separate a plain copy from a skipping walk. Source-only and destination-only masks tell compaction and expansion apart, because each shows which cursor holds still. Zero and over-range lengths, together with bases near the top of the register space, probe termination, saturation and wrap-around. A `start` pulse carrying different operands in mid-walk shows whether a busy move can be disturbed.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_FINISH = 2'd2
    } tpm_state_e;

endpackage

// File: rtl/tpm_next_set.sv
// Priority search: lowest set mask bit at or above 'from' and below 'limit'.
// Returns 'limit' when no such bit exists.
module tpm_next_set #(
    parameter int VLMAX = 16,
    parameter int IW    = $clog2(VLMAX + 1)
) (
    input  logic [VLMAX-1:0] mask,
    input  logic [IW-1:0]    from,
    input  logic [IW-1:0]    limit,
    output logic [IW-1:0]    pos
);

    always_comb begin
        pos = limit;
        for (int k = VLMAX - 1; k >= 0; k--) begin
            if (mask[k] && (IW'(k) >= from) && (IW'(k) < limit)) begin
                pos = IW'(k);
            end
        end
    end

endmodule

// File: rtl/tpm_walker.sv
// One cursor of the twin walk: holds its position, mask and vector flag,
// and presents the next usable position each cycle.
module tpm_walker #(
    parameter int VLMAX = 16,
    parameter int IW    = $clog2(VLMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             vec_in,
    input  logic [VLMAX-1:0] mask_in,
    input  logic             step,
    input  logic [IW-1:0]    limit,
    output logic [IW-1:0]    cand,
    output logic             in_range
);

    logic [IW-1:0]    idx_q;
    logic [VLMAX-1:0] mask_q;
    logic             vec_q;
    logic [IW-1:0]    found;

    tpm_next_set #(.VLMAX(VLMAX), .IW(IW)) u_search (
        .mask  (mask_q),
        .from  (idx_q),
        .limit (limit),
        .pos   (found)
    );

    always_comb begin
        cand     = vec_q ? found : idx_q;
        in_range = (cand < limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            mask_q <= '0;
            vec_q  <= 1'b0;
        end else if (load) begin
            idx_q  <= '0;
            mask_q <= mask_in;
            vec_q  <= vec_in;
        end else if (step && vec_q) begin
            idx_q  <= cand + IW'(1);
        end
    end

    // A vector cursor only offers positions whose mask bit is set (R3/R4)
    assert_cand_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_range && vec_q && !load) |-> mask_q[cand]);

    // A vector cursor strictly advances after a copy (R4)
    assert_cursor_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && vec_q && !load) |=> (idx_q > $past(idx_q)));

    // A scalar cursor never moves (R5)
    assert_scalar_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_q && !load) |=> (idx_q == $past(idx_q)));

endmodule

// File: rtl/twin_pred_mover.sv
module twin_pred_mover #(
    parameter int VLMAX = 16,
    parameter int RW    = 5,
    localparam int IW   = $clog2(VLMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             src_vec,
    input  logic             dst_vec,
    input  logic [RW-1:0]    src_base,
    input  logic [RW-1:0]    dst_base,
    input  logic [VLMAX-1:0] src_pred,
    input  logic [VLMAX-1:0] dst_pred,
    input  logic [IW-1:0]    vl,
    output logic             busy,
    output logic             copy_valid,
    output logic [RW-1:0]    copy_src,
    output logic [RW-1:0]    copy_dst,
    output logic             done
);
    import tpm_pkg::*;

    tpm_state_e    state_q, state_d;
    logic [IW-1:0] vl_q, vl_eff;
    logic [RW-1:0] sb_q, db_q;
    logic          sv_q, dv_q;
    logic          launch;
    logic [IW-1:0] s_cand, d_cand;
    logic          s_ok, d_ok;
    logic          pair_ok;

    assign launch  = (state_q == ST_IDLE) && start;
    assign vl_eff  = (vl > IW'(VLMAX)) ? IW'(VLMAX) : vl;
    assign pair_ok = s_ok && d_ok;

    tpm_walker #(.VLMAX(VLMAX), .IW(IW)) u_src_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .vec_in   (src_vec),
        .mask_in  (src_pred),
        .step     (copy_valid),
        .limit    (vl_q),
        .cand     (s_cand),
        .in_range (s_ok)
    );

    tpm_walker #(.VLMAX(VLMAX), .IW(IW)) u_dst_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .vec_in   (dst_vec),
        .mask_in  (dst_pred),
        .step     (copy_valid),
        .limit    (vl_q),
        .cand     (d_cand),
        .in_range (d_ok)
    );

    // Operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q <= '0;
            sb_q <= '0;
            db_q <= '0;
            sv_q <= 1'b0;
            dv_q <= 1'b0;
        end else if (launch) begin
            vl_q <= vl_eff;
            sb_q <= src_base;
            db_q <= dst_base;
            sv_q <= src_vec;
            dv_q <= dst_vec;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_WALK;
            ST_WALK: begin
                if (!pair_ok)             state_d = ST_FINISH; // exhaust
                else if (!sv_q && !dv_q)  state_d = ST_FINISH; // single
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy       = 1'b0;
        copy_valid = 1'b0;
        done       = 1'b0;
        copy_src   = sb_q + RW'(s_cand);
        copy_dst   = db_q + RW'(d_cand);
        unique case (state_q)
            ST_IDLE:   ;
            ST_WALK: begin
                busy       = 1'b1;
                copy_valid = pair_ok;
            end
            ST_FINISH: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default:   ;
        endcase
    end

    assert_copy_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid |-> busy);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_copy_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid |-> ((s_cand < vl_q) && (d_cand < vl_q)));

    assert_single_scalar_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_valid && !sv_q && !dv_q) |=> (!copy_valid && done));

    assert_vl_capped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (vl_q <= IW'(VLMAX)));

    assert_hold_operands_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(sb_q) && $stable(db_q) && $stable(vl_q)));

endmodule

// File: tb/twin_pred_mover_test.sv
module twin_pred_mover_test;
    localparam int VLMAX = 16;
    localparam int RW    = 5;
    localparam int IW    = $clog2(VLMAX + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             src_vec = 1'b0, dst_vec = 1'b0;
    logic [RW-1:0]    src_base = '0, dst_base = '0;
    logic [VLMAX-1:0] src_pred = '0, dst_pred = '0;
    logic [IW-1:0]    vl = '0;
    logic             busy, copy_valid, done;
    logic [RW-1:0]    copy_src, copy_dst;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    logic [2*RW-1:0] exp_q[$];

    twin_pred_mover #(.VLMAX(VLMAX), .RW(RW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_vec(src_vec), .dst_vec(dst_vec),
        .src_base(src_base), .dst_base(dst_base),
        .src_pred(src_pred), .dst_pred(dst_pred), .vl(vl),
        .busy(busy), .copy_valid(copy_valid),
        .copy_src(copy_src), .copy_dst(copy_dst), .done(done)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv,
                         input string what);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Monitor: pop expected copies as the design issues them
    always @(negedge clk) begin
        if (rst_n && copy_valid) begin
            if (exp_q.size() == 0) begin
                check(cur_req, {copy_src, copy_dst}, 32'hFFFF, "unexpected copy");
            end else begin
                logic [2*RW-1:0] item;
                item = exp_q.pop_front();
                check(cur_req, {copy_src, copy_dst}, item, "copy src/dst");
            end
        end
    end

    // Driver: model the twin walk, push expected copies, launch, time the end
    task automatic run_case(input bit sv, input bit dv,
                            input logic [VLMAX-1:0] sp, input logic [VLMAX-1:0] dp,
                            input int sb, input int db, input int vlv,
                            input string req, input bit poke);
        int i = 0, j = 0, n = 0, lat, c;
        int v = (vlv > VLMAX) ? VLMAX : vlv;
        cur_req = req;
        forever begin
            if (sv) while (i < v && !sp[i]) i++;
            if (dv) while (j < v && !dp[j]) j++;
            if (i >= v || j >= v) break;
            exp_q.push_back({RW'(sb + i), RW'(db + j)});
            n++;
            if (!sv && !dv) break;
            i += int'(sv);
            j += int'(dv);
        end
        lat = (!sv && !dv && n == 1) ? 2 : n + 2;
        @(negedge clk);
        src_vec = sv; dst_vec = dv; src_pred = sp; dst_pred = dp;
        src_base = RW'(sb); dst_base = RW'(db); vl = IW'(vlv);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        c = 1;
        if (poke) begin
            // R11: disturb every input while busy
            start = 1'b1; src_vec = ~sv; dst_vec = ~dv;
            src_pred = ~sp; dst_pred = ~dp; src_base = ~RW'(sb);
            dst_base = ~RW'(db); vl = IW'(1);
        end
        while (!done && c < 200) begin
            @(negedge clk);
            c++;
            if (poke && c == 2) start = 1'b0;
        end
        check(req, (c >= 200) ? 32'd0 : 32'd1, 32'd1, "watchdog");
        check(req, c, lat, "cycles to done (R12/R7)");
        check(req, exp_q.size(), 0, "copies left unissued");
        exp_q.delete();
        @(negedge clk);
        check(req, {done, busy}, 2'b00, "done one cycle then idle (R7)");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {busy, copy_valid, done}, 3'b000, "outputs during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {busy, copy_valid, done}, 3'b000, "outputs after reset");

        // R5 broadcast: scalar source, mask ignored
        run_case(1'b0, 1'b1, 16'h0000, 16'hFFFF, 3, 10, 8, "R5 splat", 1'b0);
        // R2 plain vector copy over full length
        run_case(1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 0, 16, 16, "R2 copy", 1'b0);
        // R3 compaction with source mask only
        run_case(1'b1, 1'b1, 16'hA5A6, 16'hFFFF, 1, 20, 12, "R3 gather", 1'b0);
        // R4 expansion with destination mask only
        run_case(1'b1, 1'b1, 16'hFFFF, 16'h3C91, 2, 18, 14, "R4 scatter", 1'b0);
        // R3/R4 both masks
        run_case(1'b1, 1'b1, 16'h5F0D, 16'hC3A7, 4, 12, 16, "R4 both masks", 1'b0);
        // R5 insert: scalar source, one-hot destination
        run_case(1'b0, 1'b1, 16'hFFFF, 16'h0040, 7, 8, 10, "R5 insert", 1'b0);
        // R3 pull-out: one-hot source, scalar destination
        run_case(1'b1, 1'b0, 16'h0020, 16'h0000, 8, 2, 9, "R3 extract", 1'b0);
        // R6 scalar to scalar, masks ignored
        run_case(1'b0, 1'b0, 16'h0000, 16'h0000, 9, 6, 5, "R6 scalar pair", 1'b0);
        // R8 zero length
        run_case(1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 0, 0, 0, "R8 vl zero", 1'b0);
        run_case(1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 1, 2, 0, "R8 scalar vl zero", 1'b0);
        // R9 over-range length saturates
        run_case(1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 0, 16, 25, "R9 vl clamp", 1'b0);
        // R10 register number wrap
        run_case(1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 28, 30, 8, "R10 wrap", 1'b0);
        // R7 empty destination mask ends at once
        run_case(1'b1, 1'b1, 16'hFFFF, 16'h0000, 0, 16, 16, "R7 empty mask", 1'b0);
        // R7 source runs out before destination
        run_case(1'b1, 1'b1, 16'h0003, 16'hFFFF, 0, 16, 16, "R7 early end", 1'b0);
        // R11 start while busy is ignored
        run_case(1'b1, 1'b1, 16'h0F0F, 16'hFFFF, 5, 21, 16, "R11 busy start", 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule